// File: doc/BRIEF.md
# Byte and Halfword Permute Unit

A purely combinational execute-stage helper for a 64-bit integer pipeline. It looks at the raw instruction word and decides whether the instruction belongs to it. If so, it rearranges the bytes or halfwords of the source operand, or sign-extends its low byte or halfword. It then returns the 64-bit value to write back, together with a write enable and the destination register index.

Encodings that fall inside its two function groups but are not valid raise a reserved-instruction flag and suppress the write. The doubleword forms are valid only while 64-bit operation is enabled. Register reads, writeback and fetch are handled by the surrounding pipeline.

Top module: `byte_permute_unit`

## Requirements
- R1: The unit claims an instruction only when bits [31:26] equal 6'b011111 and bits [5:0] equal 6'b100000 (word group) or 6'b100100 (doubleword group). For any other word, wr_en, reserved_instr and result are all zero.
- R2: A claimed instruction whose bits [25:21] are nonzero sets reserved_instr and clears wr_en.
- R3: In the word group with bits [10:6] = 5'b00010, the two bytes inside each halfword of the low 32 source bits are exchanged. The resulting 32-bit word is sign-extended from its bit 31 to 64 bits.
- R4: In the word group with bits [10:6] = 5'b10000, the result is source bit 7 copied over bits [63:8], with source bits [7:0] below it.
- R5: In the word group with bits [10:6] = 5'b11000, the result is source bit 15 copied over bits [63:16], with source bits [15:0] below it.
- R6: In the doubleword group with bits [10:6] = 5'b00010, the two bytes inside each of the four halfwords are exchanged.
- R7: In the doubleword group with bits [10:6] = 5'b00101, the four halfwords are reversed. Source [63:48] lands in [15:0], [47:32] in [31:16], [31:16] in [47:32], and [15:0] in [63:48].
- R8: The doubleword-group operations with mode64_en low set reserved_instr and clear wr_en.
- R9: In either group, any bits [10:6] value not listed above sets reserved_instr and clears wr_en.
- R10: When wr_en is high, dest_idx equals instruction bits [15:11].
- R11: Whenever wr_en is low, result is all zeros. wr_en and reserved_instr are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| src_val | input | 64 | Source operand read from the register named in bits [20:16] |
| mode64_en | input | 1 | High when 64-bit operations are permitted |
| result | output | 64 | Value to write back |
| wr_en | output | 1 | Write the result to dest_idx |
| dest_idx | output | 5 | Destination register index |
| reserved_instr | output | 1 | Claimed encoding is not valid |

## Verification
The bench goes after the sign boundaries. These are sources whose bit 7, bit 15 or swapped bit 31 is one, against neighbours where it is zero. A unit that extends from the wrong bit, or that forgets to extend the swapped word, shows up as wrong upper bits. It also sweeps the sub-operation field with every function code, the doubleword group with the mode enable in both states, and a nonzero rs field. A decoder that matches too loosely would write a result where a reserved flag is due. Patterns with distinct bytes in every lane catch a swapped lane order or a byte swap applied to the wrong halfword.

// File: rtl/permute_pkg.sv
package permute_pkg;

    localparam int XLEN      = 64;
    localparam int HALF_W    = 16;
    localparam int REG_IDX_W = 5;

    localparam logic [5:0] OPC_EXT_GROUP = 6'b011111;
    localparam logic [5:0] FN_GROUP_W    = 6'b100000;
    localparam logic [5:0] FN_GROUP_D    = 6'b100100;

    localparam logic [4:0] SUB_SWAP_B    = 5'b00010;
    localparam logic [4:0] SUB_REV_H     = 5'b00101;
    localparam logic [4:0] SUB_SEXT_B    = 5'b10000;
    localparam logic [4:0] SUB_SEXT_H    = 5'b11000;

    typedef enum logic [2:0] {
        POP_NONE,
        POP_SWAPB_W,
        POP_SEXT_B,
        POP_SEXT_H,
        POP_SWAPB_D,
        POP_REVH_D
    } perm_op_e;

    typedef struct packed {
        perm_op_e op;
        logic     claimed;
        logic     illegal;
        logic     wide;
    } perm_dec_t;

    function automatic logic [HALF_W-1:0] swap_halfword(input logic [HALF_W-1:0] h);
        return {h[7:0], h[HALF_W-1:8]};
    endfunction

    function automatic logic [XLEN-1:0] sext_from(input logic [XLEN-1:0] v, input int unsigned w);
        logic [XLEN-1:0] mask;
        mask = {XLEN{1'b1}} << w;
        return v[w-1] ? (v | mask) : (v & ~mask);
    endfunction

endpackage

// File: rtl/permute_decode.sv
module permute_decode
    import permute_pkg::*;
(
    input  logic [31:0] instr,
    input  logic        mode64_en,
    output perm_dec_t   dec
);
    logic [5:0] opc;
    logic [4:0] rs_f;
    logic [4:0] sub_f;
    logic [5:0] fn_f;

    assign opc   = instr[31:26];
    assign rs_f  = instr[25:21];
    assign sub_f = instr[10:6];
    assign fn_f  = instr[5:0];

    always_comb begin
        dec         = '0;
        dec.op      = POP_NONE;
        dec.claimed = (opc == OPC_EXT_GROUP) &&
                      ((fn_f == FN_GROUP_W) || (fn_f == FN_GROUP_D));
        if (dec.claimed) begin
            if (fn_f == FN_GROUP_W) begin
                unique case (sub_f)
                    SUB_SWAP_B: dec.op = POP_SWAPB_W;
                    SUB_SEXT_B: dec.op = POP_SEXT_B;
                    SUB_SEXT_H: dec.op = POP_SEXT_H;
                    default:    dec.op = POP_NONE;
                endcase
            end else begin
                dec.wide = 1'b1;
                unique case (sub_f)
                    SUB_SWAP_B: dec.op = POP_SWAPB_D;
                    SUB_REV_H:  dec.op = POP_REVH_D;
                    default:    dec.op = POP_NONE;
                endcase
            end
            dec.illegal = (rs_f != '0) || (dec.op == POP_NONE) ||
                          (dec.wide && !mode64_en);
        end
    end

    always_comb begin
        if (!dec.claimed) AST_UNCLAIMED_CLEAN: assert (!dec.illegal && dec.op == POP_NONE); // R1
        if (dec.wide && !mode64_en) AST_WIDE_GATED: assert (dec.illegal); // R8
    end
endmodule

// File: rtl/permute_datapath.sv
module permute_datapath
    import permute_pkg::*;
#(
    parameter int DATA_W = XLEN,
    parameter int LANE_W = HALF_W
) (
    input  perm_op_e          op,
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] res
);
    localparam int N_LANE = DATA_W / LANE_W;
    localparam int WORD_W = DATA_W / 2;

    logic [DATA_W-1:0] bswap_all;
    logic [DATA_W-1:0] hrev_all;
    logic [DATA_W-1:0] word_sx;

    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        assign bswap_all[g*LANE_W +: LANE_W] = swap_halfword(src[g*LANE_W +: LANE_W]);
        assign hrev_all[g*LANE_W +: LANE_W]  = src[(N_LANE-1-g)*LANE_W +: LANE_W];
    end

    assign word_sx = {{(DATA_W-WORD_W){bswap_all[WORD_W-1]}}, bswap_all[WORD_W-1:0]};

    always_comb begin
        unique case (op)
            POP_SWAPB_W: res = word_sx;
            POP_SEXT_B:  res = sext_from(src, 8);
            POP_SEXT_H:  res = sext_from(src, 16);
            POP_SWAPB_D: res = bswap_all;
            POP_REVH_D:  res = hrev_all;
            default:     res = '0;
        endcase
    end

    always_comb begin
        if (op == POP_SWAPB_W)
            AST_WORD_SIGNED: assert (res[DATA_W-1:WORD_W] == {(DATA_W-WORD_W){src[WORD_W-9]}}); // R3
        if (op == POP_SEXT_B)
            AST_BYTE_SIGNED: assert (res[DATA_W-1:8] == {(DATA_W-8){src[7]}}); // R4
        if (op == POP_REVH_D)
            AST_HALF_ENDS: assert (res[LANE_W-1:0] == src[DATA_W-1 -: LANE_W]); // R7
    end
endmodule

// File: rtl/byte_permute_unit.sv
module byte_permute_unit
    import permute_pkg::*;
(
    input  logic [31:0]          instr,
    input  logic [XLEN-1:0]      src_val,
    input  logic                 mode64_en,
    output logic [XLEN-1:0]      result,
    output logic                 wr_en,
    output logic [REG_IDX_W-1:0] dest_idx,
    output logic                 reserved_instr
);
    perm_dec_t       dec;
    logic [XLEN-1:0] dp_res;

    permute_decode u_decode (
        .instr     (instr),
        .mode64_en (mode64_en),
        .dec       (dec)
    );

    permute_datapath #(
        .DATA_W (XLEN),
        .LANE_W (HALF_W)
    ) u_datapath (
        .op  (dec.op),
        .src (src_val),
        .res (dp_res)
    );

    assign wr_en          = dec.claimed && !dec.illegal;
    assign reserved_instr = dec.claimed && dec.illegal;
    assign result         = wr_en ? dp_res : '0;
    assign dest_idx       = instr[15:11];

    always_comb begin
        AST_WE_XOR_RSV: assert (!(wr_en && reserved_instr)); // R11
        if (instr[25:21] != '0) AST_RS_NONZERO: assert (!wr_en); // R2
        if (!wr_en) AST_QUIET_RESULT: assert (result == '0); // R11
    end
endmodule

// File: tb/byte_permute_unit_tb.sv
module byte_permute_unit_tb;
    logic        clk = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] src_val = '0;
    logic        mode64_en = 1'b0;
    logic [63:0] result;
    logic        wr_en;
    logic [4:0]  dest_idx;
    logic        reserved_instr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    byte_permute_unit u_dut (
        .instr          (instr),
        .src_val        (src_val),
        .mode64_en      (mode64_en),
        .result         (result),
        .wr_en          (wr_en),
        .dest_idx       (dest_idx),
        .reserved_instr (reserved_instr)
    );

    function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] rs,
                                       input logic [4:0] rd, input logic [4:0] sa,
                                       input logic [5:0] fn);
        return {opc, rs, 5'd7, rd, sa, fn};
    endfunction

    task automatic check_now();
        logic [5:0]  opc = instr[31:26];
        logic [5:0]  fn  = instr[5:0];
        logic [4:0]  sa  = instr[10:6];
        bit          own = (opc == 6'h1f) && (fn == 6'h20 || fn == 6'h24);
        bit          bad = 0;
        logic [63:0] exp = '0;
        string       req = "R1";
        if (own) begin
            if (instr[25:21] != 0) begin bad = 1; req = "R2 R11"; end
            else if (fn == 6'h20) begin
                if (sa == 5'd2) begin
                    logic [31:0] w;
                    for (int i = 0; i < 4; i++) w[8*i +: 8] = src_val[8*(i^1) +: 8];
                    exp = {{32{w[31]}}, w}; req = "R3";
                end else if (sa == 5'd16) begin
                    exp = 64'($signed(src_val[7:0])); req = "R4";
                end else if (sa == 5'd24) begin
                    exp = 64'($signed(src_val[15:0])); req = "R5";
                end else begin bad = 1; req = "R9 R11"; end
            end else begin
                if (sa != 5'd2 && sa != 5'd5) begin bad = 1; req = "R9 R11"; end
                else if (!mode64_en) begin bad = 1; req = "R8 R11"; end
                else if (sa == 5'd2) begin
                    for (int i = 0; i < 8; i++) exp[8*i +: 8] = src_val[8*(i^1) +: 8];
                    req = "R6";
                end else begin
                    for (int i = 0; i < 4; i++) exp[16*i +: 16] = src_val[16*(3-i) +: 16];
                    req = "R7";
                end
            end
        end
        n_cmp++;
        if (result !== exp || wr_en !== (own && !bad) || reserved_instr !== (own && bad)) begin
            n_bad++;
            $display("FAIL %s instr=%h src=%h: result=%h we=%b rsv=%b expected result=%h we=%b rsv=%b",
                     req, instr, src_val, result, wr_en, reserved_instr, exp, own && !bad, own && bad);
        end
        if (wr_en === 1'b1 && dest_idx !== instr[15:11]) begin
            n_bad++;
            $display("FAIL R10 dest_idx=%0d expected=%0d", dest_idx, instr[15:11]);
        end
    endtask

    task automatic apply(input logic [31:0] i, input logic [63:0] s, input logic m);
        @(negedge clk);
        instr = i; src_val = s; mode64_en = m;
        @(posedge clk);
        #1 check_now();
    endtask

    initial begin
        logic [4:0] sas[5] = '{5'd2, 5'd5, 5'd16, 5'd24, 5'd0};
        // quiescent state: all-zero instruction is not claimed (R1)
        apply('0, '0, 1'b0);
        // R3 sign boundary of swapped word
        apply(mk(6'h1f, 0, 5'd3, 5'd2, 6'h20), 64'h0123456789ABCDEF, 1);
        apply(mk(6'h1f, 0, 5'd3, 5'd2, 6'h20), 64'hFFFFFFFF00007F00, 1);
        apply(mk(6'h1f, 0, 5'd3, 5'd2, 6'h20), 64'h0000000000008000, 1);
        // R4 / R5 sign boundaries
        apply(mk(6'h1f, 0, 5'd4, 5'd16, 6'h20), 64'h0000000000000080, 0);
        apply(mk(6'h1f, 0, 5'd4, 5'd16, 6'h20), 64'hFFFFFFFFFFFFFF7F, 0);
        apply(mk(6'h1f, 0, 5'd5, 5'd24, 6'h20), 64'h0000000000008000, 0);
        apply(mk(6'h1f, 0, 5'd5, 5'd24, 6'h20), 64'hFFFFFFFFFFFF7FFF, 0);
        // R6 / R7 distinct lanes
        apply(mk(6'h1f, 0, 5'd6, 5'd2, 6'h24), 64'h0123456789ABCDEF, 1);
        apply(mk(6'h1f, 0, 5'd9, 5'd5, 6'h24), 64'h0123456789ABCDEF, 1);
        // R8 wide forms gated
        apply(mk(6'h1f, 0, 5'd6, 5'd2, 6'h24), 64'h0123456789ABCDEF, 0);
        apply(mk(6'h1f, 0, 5'd9, 5'd5, 6'h24), 64'h0123456789ABCDEF, 0);
        // R2 nonzero rs, R9 unknown sub-op, R1 foreign opcode / function
        apply(mk(6'h1f, 5'd1, 5'd3, 5'd2, 6'h20), 64'h0123456789ABCDEF, 1);
        apply(mk(6'h1f, 0, 5'd3, 5'd5, 6'h20), 64'h0123456789ABCDEF, 1);
        apply(mk(6'h1f, 0, 5'd3, 5'd24, 6'h24), 64'h0123456789ABCDEF, 1);
        apply(mk(6'h1e, 0, 5'd3, 5'd2, 6'h20), 64'h0123456789ABCDEF, 1);
        apply(mk(6'h1f, 0, 5'd3, 5'd2, 6'h21), 64'h0123456789ABCDEF, 1);
        // R10 and all ops under mixed random stimulus
        for (int k = 0; k < 3000; k++) begin
            logic [5:0] opc = ($urandom_range(0, 7) == 0) ? 6'($urandom) : 6'h1f;
            logic [4:0] rs  = ($urandom_range(0, 5) == 0) ? 5'($urandom) : 5'd0;
            logic [4:0] sa  = sas[$urandom_range(0, 4)];
            logic [5:0] fn;
            if ($urandom_range(0, 5) == 0) sa = 5'($urandom);
            fn = ($urandom_range(0, 9) == 0) ? 6'($urandom) : ($urandom_range(0, 1) ? 6'h20 : 6'h24);
            apply(mk(opc, rs, 5'($urandom), sa, fn), {$urandom, $urandom}, 1'($urandom));
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule